// File: doc/BRIEF.md
# Three-Channel Timer Input Capture

This block watches three input pins and, when a pin makes a transition that its channel is set to respond to, stores the current 16-bit free-running timer value in that channel's capture register and raises the channel's flag. The timer value is not kept in the block. It is derived from a system cycle counter supplied at the boundary, minus a software-chosen offset, divided by a prescaler of 1, 4, 8 or 16.

Software programs one shared control byte with a two-bit edge mode per pin. It reads each 16-bit capture value as two bytes and clears flags by writing ones. A per-channel enable byte gates the flags onto a single interrupt request output. All state changes on the rising clock edge. Reads are combinational from the stored state.

Top module: `tri_input_capture`

## Requirements
- R1: After reset, every readable byte (addresses 0 to 8) reads 0x00, `irq` is low, and the stored pin state is 0.
- R2: Pin i is governed by control bits [2i+1:2i] of the control byte at address 6. Mode 00 never captures, 01 captures on a 0-to-1 change, 10 captures on a 1-to-0 change, and 11 captures on either change.
- R3: A capture on pin i sets bit i of the flag byte at address 7 and loads capture channel 3-i. Channel n keeps its high byte at address 2(n-1) and its low byte at address 2(n-1)+1, so pin 2 maps to addresses 0/1, pin 1 to 2/3 and pin 0 to 4/5.
- R4: The captured value is the low 16 bits of (cyc_cnt - cyc_adj) shifted right by 0, 2, 3 or 4 for `presc_sel` 0, 1, 2 or 3. The operands are the values present in the cycle whose clock edge records the capture.
- R5: A pin is examined only when its input differs from the value stored at the previous clock edge. A pin held steady causes no capture, whatever the counter does. A capture is readable in the cycle after its edge.
- R6: Writing the flag byte clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R7: When a capture sets a flag in the same cycle that a write clears it, the flag ends up set.
- R8: `irq` is high exactly when some flag bit i and enable bit i (enable byte at address 8, bits [2:0]) are both 1. It rises in the cycle after an enabled capture.
- R9: Writes to addresses 0 to 5 are ignored, and the control and enable bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_cnt | input | CW | System cycle counter |
| cyc_adj | input | CW | Offset subtracted from the cycle counter |
| presc_sel | input | 2 | Prescaler select: 0 for /1, 1 for /4, 2 for /8, 3 for /16 |
| pin_in | input | NCH | Synchronous capture pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, combinational from state |
| irq | output | 1 | Interrupt request |

## Verification
A pin change presented before a rising edge is qualified in that same cycle. Its capture value and flag are registered at that edge, so the bench checks them through the read port on the following falling edge. `irq` is derived directly from registered flags and enables, so it is due in that same cycle after the capture edge, and it follows an enable write one edge later. The bench drives every input at a falling edge, advances exactly one rising edge per stimulus, and samples one time unit after setting the read address, well clear of the next active edge.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_RISE = 2'b01,
        EM_FALL = 2'b10,
        EM_ANY  = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV4  = 2'd1,
        PS_DIV8  = 2'd2,
        PS_DIV16 = 2'd3
    } presc_e;

    function automatic int presc_shift(input int sel);
        case (sel)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ic_timebase.sv
module ic_timebase #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] cyc_cnt,
    input  logic [CW-1:0] cyc_adj,
    input  logic [1:0]    presc_sel,
    output logic [15:0]   tcount
);
    localparam int MAXSH = 4;
    localparam int NSEL  = 4;

    logic [CW-1:0]  diff;
    logic [15:0]    scaled [NSEL];
    logic           unused_hi;

    assign diff      = cyc_cnt - cyc_adj;
    assign unused_hi = ^diff[CW-1:16+MAXSH];

    for (genvar s = 0; s < NSEL; s++) begin : g_scale
        localparam int SH = ic_pkg::presc_shift(s);
        assign scaled[s] = diff[SH+15:SH];
    end

    assign tcount = scaled[presc_sel];

endmodule

// File: rtl/ic_edge_qual.sv
module ic_edge_qual
    import ic_pkg::*;
(
    input  logic       pin_now,
    input  logic       pin_prev,
    input  logic [1:0] mode,
    output logic       hit
);
    logic moved;

    assign moved = pin_now ^ pin_prev;

    always_comb begin
        hit = 1'b0;
        if (moved) begin
            case (edge_mode_e'(mode))
                EM_RISE: hit = pin_now;
                EM_FALL: hit = ~pin_now;
                EM_ANY:  hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tri_input_capture.sv
module tri_input_capture #(
    parameter int CW  = 32,
    parameter int NCH = 3,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cyc_cnt,
    input  logic [CW-1:0]  cyc_adj,
    input  logic [1:0]     presc_sel,
    input  logic [NCH-1:0] pin_in,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [7:0]     rd_data,
    output logic           irq
);
    localparam int CTLW = 2 * NCH;
    localparam logic [AW-1:0] A_CTL = AW'(2 * NCH);
    localparam logic [AW-1:0] A_FLG = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_IEN = AW'(2 * NCH + 2);

    typedef struct packed {
        logic [NCH-1:0]       pin;
        logic [NCH-1:0]       flag;
        logic [NCH-1:0]       ien;
        logic [CTLW-1:0]      ectl;
        logic [NCH-1:0][15:0] cap;
    } ic_state_t;

    ic_state_t       st_d, st_q;
    logic [15:0]     tcount;
    logic [NCH-1:0]  hit;

    ic_timebase #(.CW(CW)) u_tb (
        .cyc_cnt   (cyc_cnt),
        .cyc_adj   (cyc_adj),
        .presc_sel (presc_sel),
        .tcount    (tcount)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ic_edge_qual u_q (
            .pin_now  (pin_in[i]),
            .pin_prev (st_q.pin[i]),
            .mode     (st_q.ectl[2*i+1:2*i]),
            .hit      (hit[i])
        );
    end

    if (CTLW < 8) begin : g_unused_wd
        logic unused_wd;
        assign unused_wd = ^wr_data[7:CTLW];
    end

    always_comb begin
        logic [NCH-1:0] clr;
        st_d     = st_q;
        st_d.pin = pin_in;
        clr      = '0;
        if (wr_en && wr_addr == A_FLG) clr = wr_data[NCH-1:0];
        if (wr_en && wr_addr == A_CTL) st_d.ectl = wr_data[CTLW-1:0];
        if (wr_en && wr_addr == A_IEN) st_d.ien  = wr_data[NCH-1:0];
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) st_d.cap[NCH-1-i] = tcount;
        end
        st_d.flag = (st_q.flag & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NCH; k++) begin
            if (rd_addr == AW'(2 * k))     rd_data = st_q.cap[k][15:8];
            if (rd_addr == AW'(2 * k + 1)) rd_data = st_q.cap[k][7:0];
        end
        if (rd_addr == A_CTL) rd_data = 8'(st_q.ectl);
        if (rd_addr == A_FLG) rd_data = 8'(st_q.flag);
        if (rd_addr == A_IEN) rd_data = 8'(st_q.ien);
    end

    assign irq = |(st_q.flag & st_q.ien);

    logic [NCH-1:0]        flag_w, ien_w;
    logic [CTLW-1:0]       ectl_w;
    logic [NCH*16-1:0]     cap_w;
    assign flag_w = st_q.flag;
    assign ien_w  = st_q.ien;
    assign ectl_w = st_q.ectl;
    assign cap_w  = st_q.cap;

endmodule

// File: rtl/tri_input_capture_chk.sv
module tri_input_capture_chk #(
    parameter int NCH = 3,
    parameter int AW  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    pin_in,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [7:0]        wr_data,
    input logic [2*NCH-1:0]  ectl,
    input logic [NCH-1:0]    flag,
    input logic [NCH-1:0]    ien,
    input logic [NCH*16-1:0] cap,
    input logic              irq
);
    localparam logic [AW-1:0] A_FLG = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_IEN = AW'(2 * NCH + 2);

    logic [NCH-1:0] prev;
    logic [NCH-1:0] qual;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_in;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            case (ectl[2*i +: 2])
                2'b01:   qual[i] = !prev[i] && pin_in[i];
                2'b10:   qual[i] = prev[i] && !pin_in[i];
                2'b11:   qual[i] = prev[i] != pin_in[i];
                default: qual[i] = 1'b0;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_a
        localparam int K = NCH - 1 - i;

        a_r2_flag_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(ectl[2*i +: 2]) != 2'b00);

        a_r5_cap_moves_on_change: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cap[16*K +: 16]) |-> $past(pin_in[i] != prev[i]));

        a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            qual[i] |=> flag[i]);

        a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_FLG && wr_data[i] && !qual[i]) |=> !flag[i]);

        a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (qual[i] && ien[i] && !(wr_en && wr_addr == A_IEN)) |=> irq);
    end

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

endmodule

bind tri_input_capture tri_input_capture_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ectl    (ectl_w),
    .flag    (flag_w),
    .ien     (ien_w),
    .cap     (cap_w),
    .irq     (irq)
);

// File: tb/sim_tri_input_capture.sv
`timescale 1ns/1ps
module sim_tri_input_capture;
    localparam int CW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cyc_cnt = '0;
    logic [CW-1:0] cyc_adj = '0;
    logic [1:0]    presc_sel = 2'd0;
    logic [2:0]    pin_in = 3'b000;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tri_input_capture #(.CW(CW), .NCH(3), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_cnt(cyc_cnt), .cyc_adj(cyc_adj),
        .presc_sel(presc_sel), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [5:0]  ctl;
        logic [1:0]  ps;
        logic [31:0] cyc;
        logic [31:0] adj;
        logic [2:0]  pins;
        logic [2:0]  eflag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'h15, 2'd0, 32'h0000_1234, 32'h0000_0034, 3'b101, 3'b101},
        '{6'h15, 2'd0, 32'h0000_2000, 32'h0000_0000, 3'b000, 3'b000},
        '{6'h2A, 2'd0, 32'h0000_3000, 32'h0000_0000, 3'b010, 3'b000},
        '{6'h2A, 2'd1, 32'h0001_0400, 32'h0000_0000, 3'b000, 3'b010},
        '{6'h3F, 2'd3, 32'h00AB_CDE0, 32'h0000_0010, 3'b111, 3'b111},
        '{6'h00, 2'd0, 32'h0000_4000, 32'h0000_0000, 3'b000, 3'b000},
        '{6'h13, 2'd2, 32'h0000_0800, 32'h0000_0100, 3'b110, 3'b100},
        '{6'h13, 2'd0, 32'hFFFF_0000, 32'hFFFE_FFF8, 3'b011, 3'b001},
        '{6'h3F, 2'd0, 32'h0000_0005, 32'h0000_000A, 3'b001, 3'b010}
    };

    function automatic logic [15:0] exp_count(input logic [31:0] c, input logic [31:0] a,
                                              input logic [1:0] ps);
        logic [31:0] d;
        d = c - a;
        case (ps)
            2'd0: return d[15:0];
            2'd1: return d[17:2];
            2'd2: return d[18:3];
            default: return d[19:4];
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd16(input int k, output logic [15:0] v);
        logic [7:0] h, l;
        rd(AW'(2 * k), h);
        rd(AW'(2 * k + 1), l);
        v = {h, l};
    endtask

    initial begin : main
        logic [7:0]  b;
        logic [15:0] v, keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(AW'(a), b);
            chk("R1 reset byte", 16'(b), 16'h0000);
        end
        chk("R1 irq low", 16'(irq), 16'h0000);

        // Vector table: R2 modes, R3 mapping, R4 value, R5 change-only
        for (int n = 0; n < NV; n++) begin
            wr(AW'(6), {2'b00, VECS[n].ctl});
            wr(AW'(7), 8'h07);
            presc_sel = VECS[n].ps;
            cyc_cnt   = VECS[n].cyc;
            cyc_adj   = VECS[n].adj;
            pin_in    = VECS[n].pins;
            tick();
            rd(AW'(7), b);
            chk("R2 R3 flags", 16'(b), 16'(VECS[n].eflag));
            for (int i = 0; i < 3; i++) begin
                if (VECS[n].eflag[i]) begin
                    rd16(2 - i, v);
                    chk("R3 R4 capture", v, exp_count(VECS[n].cyc, VECS[n].adj, VECS[n].ps));
                end
            end
        end

        // R6 write-one-to-clear (ctl is 0x3F, pins 001)
        wr(AW'(7), 8'h07);
        pin_in = 3'b110;
        cyc_cnt = 32'h0000_0777; cyc_adj = '0; presc_sel = 2'd0;
        tick();
        rd(AW'(7), b);
        chk("R6 all set", 16'(b), 16'h0007);
        wr(AW'(7), 8'h02);
        rd(AW'(7), b);
        chk("R6 clear one", 16'(b), 16'h0005);
        wr(AW'(7), 8'h00);
        rd(AW'(7), b);
        chk("R6 zero write", 16'(b), 16'h0005);

        // R8 interrupt gating
        chk("R8 irq no enable", 16'(irq), 16'h0000);
        wr(AW'(8), 8'h04);
        chk("R8 irq enabled flag", 16'(irq), 16'h0001);
        rd(AW'(8), b);
        chk("R9 enable readback", 16'(b), 16'h0004);
        wr(AW'(7), 8'h04);
        chk("R8 irq after clear", 16'(irq), 16'h0000);

        // R7 set beats clear in the same cycle
        wr(AW'(7), 8'h07);
        wr_en = 1'b1; wr_addr = AW'(7); wr_data = 8'h01;
        pin_in = 3'b111;
        cyc_cnt = 32'h0000_1111;
        tick();
        wr_en = 1'b0;
        rd(AW'(7), b);
        chk("R7 set wins", 16'(b), 16'h0001);
        rd16(2, v);
        chk("R7 R4 capture", v, 16'h1111);

        // R5 steady pins: no new capture
        keep = v;
        wr(AW'(7), 8'h07);
        for (int t = 0; t < 4; t++) begin
            cyc_cnt = cyc_cnt + 32'd97;
            tick();
        end
        rd(AW'(7), b);
        chk("R5 no flag on steady pin", 16'(b), 16'h0000);
        rd16(2, v);
        chk("R5 capture held", v, keep);

        // R9 capture registers are not writable, control reads back
        for (int a = 0; a < 6; a++) wr(AW'(a), 8'hA5);
        rd16(2, v);
        chk("R9 capture unwritable", v, keep);
        rd(AW'(6), b);
        chk("R9 control readback", 16'(b), 16'h003F);

        // R8 irq due the cycle after an enabled capture
        wr(AW'(8), 8'h01);
        chk("R8 irq before edge", 16'(irq), 16'h0000);
        pin_in = 3'b110;
        tick();
        chk("R8 irq after edge", 16'(irq), 16'h0001);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule